// File: doc/BRIEF.md
# Complementary-Mosaic Line Luminance/Chroma Separator

This block sits directly behind the digitiser of an interline CCD whose on-chip filters are yellow, cyan, magenta and green. The sensor sums charge from two vertically adjacent photosites, so every incoming sample already carries two filter colours. The block works out where each sample lies in the frame. It removes a black level measured from shielded pixels. From each adjacent pair of effective samples it produces one luminance value and one colour-difference value.

On one kind of line the samples alternate between green+cyan and magenta+yellow. The difference of a pair then approximates 2R-G and is reported as R-Y. On the other kind of line the samples alternate between magenta+cyan and green+yellow. The difference then approximates 2B-G and is reported as B-Y. The kind of line swaps on every effective line. A configuration input selects which kind the first effective line of a frame is, so that either field of an interlaced readout can be handled.

The black level is the mean of the first 2^AVG_LOG2 shielded samples at the rear of each line. It applies to the lines that follow and is cleared at the start of each frame. Input samples arrive with a valid qualifier and with strobes that mark the start of a line and the start of a frame.

Top module: `ycs_line_separator`

## Requirements
- R1: The pixel index restarts at 0 on a valid sample that carries the line or frame strobe and otherwise advances by one per valid sample. The line index restarts at 0 on a valid sample with the frame strobe and advances on each further valid line strobe.
- R2: A result (out_valid high for one cycle) is produced one clock after the second sample of each pair of effective samples, and never otherwise. Effective samples are pixel indices H_FRONT_OB to H_FRONT_OB+H_ACTIVE-1 on line indices V_TOP_OB to V_TOP_OB+V_ACTIVE-1. Pairs start at the first effective pixel of every line, giving H_ACTIVE/2 results per effective line. No result is produced before the first frame strobe.
- R3: The black level is the sum of the samples at pixel indices H_FRONT_OB+H_ACTIVE up to H_FRONT_OB+H_ACTIVE+2^AVG_LOG2-1, shifted right by AVG_LOG2. It takes effect on the sample after the last of these and is cleared to 0 by a valid frame strobe.
- R4: Each effective sample is corrected as sample minus black level, clamped at 0 when the black level is larger.
- R5: y_out equals (a+b)>>1, where a and b are the corrected first and second samples of the pair.
- R6: c_out is the 11-bit two's-complement value b-a.
- R7: c_is_bmy is 0 for R-Y and 1 for B-Y. It equals cfg_first_bmy (sampled with the frame strobe) on the first effective line and inverts on each following effective line.
- R8: Cycles with in_valid low change no index, black level or pairing state, and their strobes and data are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample qualifier |
| in_data | input | DW | Unsigned raw sample |
| in_line_start | input | 1 | First sample of a line |
| in_frame_start | input | 1 | First sample of a frame |
| cfg_first_bmy | input | 1 | Chroma type of the first effective line (1 = B-Y) |
| out_valid | output | 1 | Result strobe |
| y_out | output | DW | Luminance |
| c_out | output | DW+1 | Signed colour difference |
| c_is_bmy | output | 1 | Chroma type of c_out |

## Verification
The clamp at zero and the forming of a result can fall in the same cycle: the second sample of a pair can lie below the black level while the first does not, or the reverse. The bench provokes this with frames whose effective samples are drawn at random over the whole range, and with a frame whose samples all lie at or below a noisy black level. The bench's model clamps each sample on its own before it takes the half-sum and the difference, so a clamp applied to the pair as a whole, or one that wraps, shows up in y_out or in the sign of c_out.

// File: rtl/ycs_pkg.sv
package ycs_pkg;
   typedef enum logic {
      CT_RMY = 1'b0,
      CT_BMY = 1'b1
   } ctype_e;
endpackage

// File: rtl/ycs_position.sv
module ycs_position #(
   parameter int H_FRONT_OB = 3,
   parameter int H_ACTIVE   = 752,
   parameter int H_REAR_OB  = 40,
   parameter int V_TOP_OB   = 12,
   parameter int V_ACTIVE   = 582,
   parameter int V_BOT_OB   = 2,
   parameter int AVG_LOG2   = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic line_start_i,
   input  logic frame_start_i,
   input  logic cfg_bmy_i,
   output logic eff_o,
   output logic second_o,
   output logic bmy_o,
   output logic avg_en_o,
   output logic avg_last_o,
   output logic fs_o
);
   localparam int LINE_LEN   = H_FRONT_OB + H_ACTIVE + H_REAR_OB;
   localparam int LINES      = V_TOP_OB + V_ACTIVE + V_BOT_OB;
   localparam int PIX_W      = $clog2(LINE_LEN + 1);
   localparam int LINE_W     = $clog2(LINES + 1);
   localparam int REAR_START = H_FRONT_OB + H_ACTIVE;
   localparam int AVG_N      = 1 << AVG_LOG2;
   localparam logic FRONT_ODD = logic'(H_FRONT_OB % 2);
   localparam logic TOP_ODD   = logic'(V_TOP_OB % 2);

   logic [PIX_W-1:0]  pix_q, pix_now;
   logic [LINE_W-1:0] line_q, line_now;
   logic              framed_q, framed_now, cfg_q, cfg_now;
   logic              h_eff, v_eff, in_win;

   always_comb begin
      pix_now    = (line_start_i || frame_start_i) ? '0 : pix_q;
      if (frame_start_i)
         line_now = '0;
      else if (line_start_i && (int'(line_q) < LINES))
         line_now = line_q + 1'b1;
      else
         line_now = line_q;
      framed_now = framed_q || frame_start_i;
      cfg_now    = frame_start_i ? cfg_bmy_i : cfg_q;
      h_eff      = (int'(pix_now) >= H_FRONT_OB) && (int'(pix_now) < REAR_START);
      v_eff      = (int'(line_now) >= V_TOP_OB) && (int'(line_now) < V_TOP_OB + V_ACTIVE);
      in_win     = (int'(pix_now) >= REAR_START) && (int'(pix_now) < REAR_START + AVG_N);
   end

   assign eff_o      = in_valid && framed_now && h_eff && v_eff;
   assign second_o   = pix_now[0] ^ FRONT_ODD;
   assign bmy_o      = cfg_now ^ line_now[0] ^ TOP_ODD;
   assign avg_en_o   = in_valid && framed_now && in_win;
   assign avg_last_o = (int'(pix_now) == REAR_START + AVG_N - 1);
   assign fs_o       = in_valid && frame_start_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_q    <= '0;
         line_q   <= '0;
         framed_q <= 1'b0;
         cfg_q    <= 1'b0;
      end else if (in_valid) begin
         pix_q    <= (int'(pix_now) >= LINE_LEN) ? pix_now : pix_now + 1'b1;
         line_q   <= line_now;
         framed_q <= framed_now;
         cfg_q    <= cfg_now;
      end
   end

   assert_pix_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pix_q) <= LINE_LEN);
   assert_line_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && line_start_i) |=> (pix_q == PIX_W'(1)));
   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(pix_q) && $stable(line_q)));
endmodule

// File: rtl/ycs_black.sv
module ycs_black #(
   parameter int DW       = 10,
   parameter int AVG_LOG2 = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fs_i,
   input  logic          avg_en_i,
   input  logic          avg_last_i,
   input  logic [DW-1:0] sample_i,
   output logic [DW-1:0] black_o
);
   logic [DW-1:0] black_q;

   generate
      if (AVG_LOG2 == 0) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       black_q <= '0;
            else if (fs_i)                    black_q <= '0;
            else if (avg_en_i && avg_last_i)  black_q <= sample_i;
         end
      end else begin : g_accum
         localparam int AW = DW + AVG_LOG2;
         logic [AW-1:0] acc_q, acc_nxt;
         assign acc_nxt = acc_q + AW'(sample_i);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_q   <= '0;
               black_q <= '0;
            end else if (fs_i) begin
               acc_q   <= '0;
               black_q <= '0;
            end else if (avg_en_i) begin
               if (avg_last_i) begin
                  black_q <= acc_nxt[AVG_LOG2 +: DW];
                  acc_q   <= '0;
               end else begin
                  acc_q   <= acc_nxt;
               end
            end
         end
      end
   endgenerate

   assign black_o = black_q;

   assert_frame_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fs_i |=> (black_o == '0));
   assert_black_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!avg_en_i && !fs_i) |=> $stable(black_o));
endmodule

// File: rtl/ycs_pair.sv
module ycs_pair
   import ycs_pkg::*;
#(
   parameter int DW = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                eff_i,
   input  logic                second_i,
   input  logic                bmy_i,
   input  logic [DW-1:0]       sample_i,
   input  logic [DW-1:0]       black_i,
   output logic                out_valid_o,
   output logic [DW-1:0]       y_o,
   output logic signed [DW:0]  c_o,
   output logic                bmy_o
);
   logic [DW-1:0]      corr, first_q;
   logic [DW:0]        sum;
   logic               ov_q;
   logic [DW-1:0]      y_q;
   logic signed [DW:0] c_q;
   ctype_e             ct_q;

   assign corr = (sample_i > black_i) ? (sample_i - black_i) : '0;
   assign sum  = {1'b0, first_q} + {1'b0, corr};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= '0;
         ov_q    <= 1'b0;
         y_q     <= '0;
         c_q     <= '0;
         ct_q    <= CT_RMY;
      end else begin
         ov_q <= eff_i && second_i;
         if (eff_i && !second_i)
            first_q <= corr;
         if (eff_i && second_i) begin
            y_q  <= sum[DW:1];
            c_q  <= $signed({1'b0, corr}) - $signed({1'b0, first_q});
            ct_q <= ctype_e'(bmy_i);
         end
      end
   end

   assign out_valid_o = ov_q;
   assign y_o         = y_q;
   assign c_o         = c_q;
   assign bmy_o       = (ct_q == CT_BMY);

   assert_one_per_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |=> !out_valid_o);
   assert_from_eff_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> $past(eff_i));
   assert_c_small_when_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && y_o == '0) |-> (c_o >= -1 && c_o <= 1));
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(eff_i && second_i) |=> ($stable(y_o) && $stable(c_o)));
endmodule

// File: rtl/ycs_line_separator.sv
module ycs_line_separator #(
   parameter int DW         = 10,
   parameter int H_FRONT_OB = 3,
   parameter int H_ACTIVE   = 752,
   parameter int H_REAR_OB  = 40,
   parameter int V_TOP_OB   = 12,
   parameter int V_ACTIVE   = 582,
   parameter int V_BOT_OB   = 2,
   parameter int AVG_LOG2   = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [DW-1:0]       in_data,
   input  logic                in_line_start,
   input  logic                in_frame_start,
   input  logic                cfg_first_bmy,
   output logic                out_valid,
   output logic [DW-1:0]       y_out,
   output logic signed [DW:0]  c_out,
   output logic                c_is_bmy
);
   generate
      if (H_ACTIVE % 2 != 0) begin : g_bad_active
         $error("H_ACTIVE must be even");
      end
      if ((1 << AVG_LOG2) > H_REAR_OB) begin : g_bad_avg
         $error("averaging window exceeds rear shielded pixels");
      end
      if (DW < 2) begin : g_bad_dw
         $error("DW too small");
      end
   endgenerate

   logic eff, second, bmy, avg_en, avg_last, fs;
   logic [DW-1:0] black;

   ycs_position #(
      .H_FRONT_OB(H_FRONT_OB), .H_ACTIVE(H_ACTIVE), .H_REAR_OB(H_REAR_OB),
      .V_TOP_OB(V_TOP_OB), .V_ACTIVE(V_ACTIVE), .V_BOT_OB(V_BOT_OB),
      .AVG_LOG2(AVG_LOG2)
   ) u_pos (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .line_start_i(in_line_start), .frame_start_i(in_frame_start),
      .cfg_bmy_i(cfg_first_bmy),
      .eff_o(eff), .second_o(second), .bmy_o(bmy),
      .avg_en_o(avg_en), .avg_last_o(avg_last), .fs_o(fs)
   );

   ycs_black #(.DW(DW), .AVG_LOG2(AVG_LOG2)) u_blk (
      .clk(clk), .rst_n(rst_n), .fs_i(fs), .avg_en_i(avg_en),
      .avg_last_i(avg_last), .sample_i(in_data), .black_o(black)
   );

   ycs_pair #(.DW(DW)) u_pair (
      .clk(clk), .rst_n(rst_n), .eff_i(eff), .second_i(second), .bmy_i(bmy),
      .sample_i(in_data), .black_i(black),
      .out_valid_o(out_valid), .y_o(y_out), .c_o(c_out), .bmy_o(c_is_bmy)
   );

   assert_out_needs_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));
endmodule

// File: tb/tb_ycs_line_separator.sv
module tb_ycs_line_separator;
   localparam int DW = 10, HF = 3, HA = 16, HR = 40, VT = 2, VA = 6, VB = 2, AL = 5;
   localparam int LEN = HF + HA + HR, LINES = VT + VA + VB;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 0, ls = 0, fs = 0, cfg = 0;
   logic [DW-1:0] din = '0;
   logic out_valid, c_is_bmy;
   logic [DW-1:0] y_out;
   logic signed [DW:0] c_out;

   int total = 0, bad = 0, outs = 0;
   int qy[$], qc[$], qt[$];

   always #10 clk = ~clk;

   ycs_line_separator #(.DW(DW), .H_FRONT_OB(HF), .H_ACTIVE(HA), .H_REAR_OB(HR),
      .V_TOP_OB(VT), .V_ACTIVE(VA), .V_BOT_OB(VB), .AVG_LOG2(AL)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(din),
      .in_line_start(ls), .in_frame_start(fs), .cfg_first_bmy(cfg),
      .out_valid(out_valid), .y_out(y_out), .c_out(c_out), .c_is_bmy(c_is_bmy));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: compares each result with the model queue
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         outs++;
         if (qy.size() == 0) chk(0, "R2 unexpected result", 1, 0);
         else begin
            int ey, ec, et;
            ey = qy.pop_front(); ec = qc.pop_front(); et = qt.pop_front();
            chk(int'(y_out) == ey, "R5 R4 R3 luminance", int'(y_out), ey);
            chk(int'(c_out) == ec, "R6 R4 chroma", int'(c_out), ec);
            chk(int'(c_is_bmy) == et, "R7 chroma type", int'(c_is_bmy), et);
         end
      end
   end

   int m_black, m_acc, m_first;

   task automatic drive(input logic [DW-1:0] d, input bit l, input bit f, input bit gaps);
      if (gaps && ($urandom % 3 == 0)) begin
         @(negedge clk);
         in_valid = 0; din = DW'($urandom); ls = 1'($urandom); fs = 1'($urandom);  // R8 junk
      end
      @(negedge clk);
      in_valid = 1; din = d; ls = l; fs = f;
   endtask

   // mode 0: colour pattern, 1: random full range, 2: dark (below black)
   task automatic run_frame(input bit c0, input int mode, input int blk, input bit gaps);
      int ye, cy, mg, g;
      ye = $urandom % 200; cy = $urandom % 200; mg = $urandom % 200; g = $urandom % 200;
      @(negedge clk); cfg = c0;
      outs = 0;
      for (int l = 0; l < LINES; l++) begin
         for (int p = 0; p < LEN; p++) begin
            int v, t, k;
            bit eff;
            eff = (p >= HF) && (p < HF + HA) && (l >= VT) && (l < VT + VA);
            t = (l >= VT) ? (c0 ^ ((l - VT) & 1)) : 0;
            k = p - HF;
            if (!eff) v = (mode == 0) ? blk : blk + int'($urandom % 8);
            else if (mode == 0) begin
               if (t == 0) v = blk + (((k & 1) == 0) ? g + cy : mg + ye);
               else        v = blk + (((k & 1) == 0) ? mg + cy : g + ye);
            end else if (mode == 1) v = $urandom % 1024;
            else v = $urandom % (blk + 1);
            if (l == 0 && p == 0) begin m_black = 0; m_acc = 0; end
            drive(DW'(v), p == 0, (l == 0 && p == 0), gaps);
            if (eff) begin
               int cv;
               cv = (v > m_black) ? v - m_black : 0;
               if ((k & 1) == 0) m_first = cv;
               else begin
                  qy.push_back((m_first + cv) >> 1);
                  qc.push_back(cv - m_first);
                  qt.push_back(t);
               end
            end
            if (p >= HF + HA && p < HF + HA + (1 << AL)) begin
               m_acc += v;
               if (p == HF + HA + (1 << AL) - 1) begin m_black = m_acc >> AL; m_acc = 0; end
            end
         end
      end
      @(negedge clk); in_valid = 0; ls = 0; fs = 0;
      repeat (4) @(negedge clk);
      chk(qy.size() == 0, "R2 pending results", qy.size(), 0);
      chk(outs == VA * HA / 2, "R2 result count", outs, VA * HA / 2);
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      chk(out_valid == 0, "R2 reset out_valid", int'(out_valid), 0);
      chk(y_out == 0 && c_out == 0, "R5 reset outputs", int'(y_out), 0);
      rst_n = 1;
      // samples before any frame strobe give no result (R2)
      outs = 0;
      for (int i = 0; i < 30; i++) drive(DW'(500), i == 0, 0, 0);
      @(negedge clk); in_valid = 0; repeat (3) @(negedge clk);
      chk(outs == 0, "R2 no result before frame", outs, 0);
      run_frame(0, 0, 64, 0);   // R7 start R-Y, R1 positions
      run_frame(1, 0, 64, 0);   // R7 start B-Y
      run_frame(0, 0, 100, 1);  // R8 gaps with junk strobes
      run_frame(1, 1, 30, 1);   // R4 clamp coinciding with pair formation
      run_frame(0, 2, 120, 0);  // R4 dark frame, R3 noisy average
      run_frame(1, 1, 0, 0);    // R3 zero black
      for (int i = 0; i < 3; i++) run_frame(1'($urandom), int'($urandom % 3), int'($urandom % 128), 1'($urandom));
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule